// File: doc/BRIEF.md
# Dual-Mode Bidirectional Bus Transceiver

The block links two 18-bit bidirectional buses, an A side and a B side. The forward path copies A onto B. The reverse path copies B onto A. Each path has one storage cell per bit, and three inputs of its own set how that cell behaves:

- a latch enable,
- a data clock,
- an output enable.

When the latch enable is high, the path is transparent and the destination follows the source. When the latch enable is low, the cell holds its contents. It reloads from the source only when its data clock goes from high to low. The forward output enable is active high. The reverse output enable is active low. While a path is disabled, its destination bus is released so that another device can drive it.

The whole block runs on one fast system clock. The two data clocks are sampled in that domain through a two-stage synchronizer, and a falling edge is recognised when the sampled value goes from one to zero. Transparent operation is a combinational bypass around the stored register. While the block itself drives a bus, the opposite path reads the driving path's stored word in place of that bus. This breaks the combinational loop that two transparent paths would otherwise form.

Top module: `dual_mode_bus_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both stored words to zero. After reset, with the latch enable low, an enabled destination shows all zeros.
- R2: With the forward latch enable high and the forward path enabled, B equals A in the same cycle and follows every change of A.
- R3: With the forward latch enable low, a high-to-low transition of the forward data clock loads the A word. B shows it no later than four system clocks after the transition. A low-to-high transition loads nothing.
- R4: With the forward latch enable low and the forward data clock steady, B keeps its earlier value whatever A does. This holds both with the clock held low and with the clock high, when the clock was already high as the latch enable fell.
- R5: Forward output enable is active high. While it is 0 the block does not drive B, and a value driven on B from outside reads back unchanged.
- R6: Reverse output enable is active low. While it is 1 the block does not drive A, and a value driven on A from outside reads back unchanged.
- R7: The reverse path follows the rules of R2 to R4 with B as source, A as destination, and its own latch enable and data clock.
- R8: All 18 bits act alike. All-ones and alternating-bit patterns pass through every bit position unchanged.
- R9: Both paths can load on the same falling edge of their data clocks, each taking its own source word, with neither disturbing the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the controls and updates the storage |
| rst_n | input | 1 | Synchronous reset, active low |
| a_bus | inout | 18 | A-side bus: source of the forward path, destination of the reverse path |
| b_bus | inout | 18 | B-side bus: destination of the forward path, source of the reverse path |
| fwd_oe | input | 1 | Forward output enable, 1 drives B |
| fwd_le | input | 1 | Forward latch enable, 1 selects transparent |
| fwd_clk | input | 1 | Forward data clock, falling edge loads |
| rev_oe_n | input | 1 | Reverse output enable, 0 drives A |
| rev_le | input | 1 | Reverse latch enable, 1 selects transparent |
| rev_clk | input | 1 | Reverse data clock, falling edge loads |

## Verification
The two paths can each load a word on the same system clock. The bench provokes this by releasing both buses, placing different words on A and B from outside, and dropping both data clocks on the same cycle. It then enables each destination in turn. B must show the word that was on A, and A must show the word that was on B, which exposes any crossed or shared storage. Hold and edge-capture modes also meet in one cycle when a latch enable falls while the data clock is high. The bench checks that this leaves the last transparent word in place and does not trigger a load.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the dual-mode bus transceiver.
// Assumes: nothing beyond standard SystemVerilog.
package xcvr_pkg;

    // Operating mode of one storage cell, decoded once per path.
    typedef enum logic [1:0] {
        CELL_PASS    = 2'd0,   // transparent: output follows input
        CELL_LOAD    = 2'd1,   // falling data-clock edge: store input
        CELL_KEEP    = 2'd2    // keep stored value
    } cell_mode_t;

endpackage

// File: rtl/xcvr_edge_sync.sv
// Module: xcvr_edge_sync
// Brings an asynchronous data clock into the system clock domain through a
// chain of SYNC_STAGES flops and flags a one-cycle pulse on each high-to-low
// transition. Assumes the raw input stays in each state for at least
// SYNC_STAGES + 1 system clocks.
module xcvr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic fall_pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Purpose: shift the raw input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], raw_in};
        end
    end

    // Purpose: last two stages compare old-high against new-low.
    always_comb begin
        fall_pulse = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];
    end

    // A falling edge cannot repeat on consecutive cycles.
    assert_single_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/xcvr_bit_cell.sv
// Module: xcvr_bit_cell
// One bit of storage: a register loaded in PASS and LOAD modes and kept in
// KEEP mode, plus a bypass mux that presents the live input in PASS mode.
// Assumes the mode is decoded by the enclosing path.
module xcvr_bit_cell
    import xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_t mode,
    input  logic       din,
    output logic       dout,
    output logic       held
);
    logic store_q;

    // Purpose: update the stored bit according to the decoded mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= 1'b0;
        end else begin
            case (mode)
                CELL_PASS: store_q <= din;
                CELL_LOAD: store_q <= din;
                default:   store_q <= store_q;
            endcase
        end
    end

    // Purpose: transparent bypass around the register.
    always_comb begin
        dout = (mode == CELL_PASS) ? din : store_q;
        held = store_q;
    end

endmodule

// File: rtl/xcvr_path.sv
// Module: xcvr_path
// One direction of the transceiver: synchronizes the data clock, decodes the
// cell mode from latch enable and detected edge, and holds BUS_W identical
// cells. Assumes din is already resolved from the source bus.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int BUS_W       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic             dclk,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] dout,
    output logic [BUS_W-1:0] held
);
    logic       fall;
    cell_mode_t mode;

    xcvr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (dclk),
        .fall_pulse (fall)
    );

    // Purpose: latch enable wins; otherwise an edge loads, else keep.
    always_comb begin
        if (le)        mode = CELL_PASS;
        else if (fall) mode = CELL_LOAD;
        else           mode = CELL_KEEP;
    end

    for (genvar i = 0; i < BUS_W; i++) begin : g_cell
        xcvr_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .din   (din[i]),
            .dout  (dout[i]),
            .held  (held[i])
        );
    end

    // Transparent mode presents the source word unchanged.
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        le |-> dout == din);

    // A detected falling edge with latch enable low loads the source word.
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && fall) |=> held == $past(din));

    // Without latch enable or edge the stored word does not move.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !fall) |=> held == $past(held));

endmodule

// File: rtl/dual_mode_bus_xcvr.sv
// Module: dual_mode_bus_xcvr
// Top of the bidirectional transceiver: a forward path A->B and a reverse
// path B->A, each with tri-state drive of its destination bus. Assumes the
// system clock is several times faster than either data clock and that the
// environment never drives a bus the block is driving.
module dual_mode_bus_xcvr #(
    parameter int BUS_W       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    inout  wire  [BUS_W-1:0] a_bus,
    inout  wire  [BUS_W-1:0] b_bus,
    input  logic             fwd_oe,
    input  logic             fwd_le,
    input  logic             fwd_clk,
    input  logic             rev_oe_n,
    input  logic             rev_le,
    input  logic             rev_clk
);
    localparam logic [BUS_W-1:0] RELEASED = {BUS_W{1'bz}};

    logic             rev_drive;
    logic [BUS_W-1:0] fwd_src, rev_src;
    logic [BUS_W-1:0] fwd_dout, rev_dout;
    logic [BUS_W-1:0] fwd_held, rev_held;

    // Purpose: pick each path's source, using the peer's stored word while
    // the block drives that bus so no loop forms.
    always_comb begin
        rev_drive = ~rev_oe_n;
        fwd_src   = rev_drive ? rev_held : a_bus;
        rev_src   = fwd_oe    ? fwd_held : b_bus;
    end

    xcvr_path #(.BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (fwd_le),
        .dclk  (fwd_clk),
        .din   (fwd_src),
        .dout  (fwd_dout),
        .held  (fwd_held)
    );

    xcvr_path #(.BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) u_rev (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (rev_le),
        .dclk  (rev_clk),
        .din   (rev_src),
        .dout  (rev_dout),
        .held  (rev_held)
    );

    assign b_bus = fwd_oe    ? fwd_dout : RELEASED;
    assign a_bus = rev_drive ? rev_dout : RELEASED;

    // Forward transparent and enabled: B carries the word seen on A.
    assert_fwd_flow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_oe && fwd_le && !rev_drive) |-> b_bus == a_bus);

    // Reverse transparent and enabled: A carries the word seen on B.
    assert_rev_flow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_drive && rev_le && !fwd_oe) |-> a_bus == b_bus);

endmodule

// File: tb/sim_dual_mode_bus_xcvr.sv
module sim_dual_mode_bus_xcvr;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_oe = 1'b1, fwd_le = 1'b0, fwd_clk = 1'b0;
    logic rev_oe_n = 1'b1, rev_le = 1'b0, rev_clk = 1'b0;
    logic [W-1:0] a_drv = '0, b_drv = '0;
    logic a_en, b_en;
    wire  [W-1:0] a_bus, b_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string        tag;
        logic [W-1:0] exp;
        bit           on_b;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    // The bench drives a bus only when the block has released it.
    always_comb begin
        a_en = rev_oe_n;
        b_en = ~fwd_oe;
    end
    assign a_bus = a_en ? a_drv : {W{1'bz}};
    assign b_bus = b_en ? b_drv : {W{1'bz}};

    dual_mode_bus_xcvr u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_bus    (a_bus),
        .b_bus    (b_bus),
        .fwd_oe   (fwd_oe),
        .fwd_le   (fwd_le),
        .fwd_clk  (fwd_clk),
        .rev_oe_n (rev_oe_n),
        .rev_le   (rev_le),
        .rev_clk  (rev_clk)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_port(input string tag, input bit on_b, input logic [W-1:0] v);
        exp_item_t it;
        it.tag = tag; it.exp = v; it.on_b = on_b;
        sb_q.push_back(it);
        tick(1);
    endtask

    // Monitor: compares queued expectations after each rising edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [W-1:0] got;
                it  = sb_q.pop_front();
                got = it.on_b ? b_bus : a_bus;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        a_drv = 18'h0F0F0;
        tick(4);
        rst_n = 1'b1;
        tick(3);
        expect_port("R1 forward reset word", 1, 18'h00000);

        // R2 transparent forward
        fwd_le = 1'b1; a_drv = 18'h2A5A5; tick(1);
        expect_port("R2 transparent pattern 1", 1, 18'h2A5A5);
        a_drv = 18'h15A5A; tick(1);
        expect_port("R2 transparent follows change", 1, 18'h15A5A);

        // R4 hold with clock high: clock rises while transparent, then LE falls
        fwd_clk = 1'b1; tick(5);
        fwd_le = 1'b0; tick(1);
        a_drv = 18'h3FFFF; tick(5);
        expect_port("R4 hold clock high", 1, 18'h15A5A);

        // R3 falling edge capture, R8 all ones
        fwd_clk = 1'b0; tick(5);
        expect_port("R3 R8 edge capture all ones", 1, 18'h3FFFF);

        // R4 hold clock low
        a_drv = 18'h00F0F; tick(5);
        expect_port("R4 hold clock low", 1, 18'h3FFFF);

        // R3 rising edge does not load
        fwd_clk = 1'b1; tick(6);
        expect_port("R3 rising edge ignored", 1, 18'h3FFFF);
        fwd_clk = 1'b0; tick(5);
        expect_port("R3 second falling edge", 1, 18'h00F0F);

        // R5 forward release
        fwd_oe = 1'b0; b_drv = 18'h12345; tick(2);
        expect_port("R5 B released", 1, 18'h12345);

        // R1 reverse reset word, R6 reverse enabled
        rev_oe_n = 1'b0; tick(2);
        expect_port("R1 reverse reset word", 0, 18'h00000);

        // R7 reverse transparent, R8 alternating bits
        rev_le = 1'b1; b_drv = 18'h2AAAA; tick(1);
        expect_port("R7 R8 reverse transparent", 0, 18'h2AAAA);
        b_drv = 18'h15555; tick(1);
        expect_port("R7 R8 reverse transparent alt", 0, 18'h15555);

        // R7 reverse hold and capture
        rev_le = 1'b0; tick(1);
        b_drv = 18'h01234; tick(5);
        expect_port("R7 reverse hold", 0, 18'h15555);
        rev_clk = 1'b1; tick(5);
        rev_clk = 1'b0; tick(5);
        expect_port("R7 reverse edge capture", 0, 18'h01234);

        // R6 reverse release
        rev_oe_n = 1'b1; a_drv = 18'h0ABCD; tick(2);
        expect_port("R6 A released", 0, 18'h0ABCD);

        // R9 both paths load on the same edge
        a_drv = 18'h24680; b_drv = 18'h13579;
        fwd_clk = 1'b1; rev_clk = 1'b1; tick(5);
        fwd_clk = 1'b0; rev_clk = 1'b0; tick(6);
        fwd_oe = 1'b1; tick(2);
        expect_port("R9 forward took A word", 1, 18'h24680);
        fwd_oe = 1'b0; tick(1);
        rev_oe_n = 1'b0; tick(2);
        expect_port("R9 reverse took B word", 0, 18'h13579);

        tick(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule